// File: doc/BRIEF.md
# Adaptive clock recovery frequency controller

This block is the digital loop filter of an adaptive clock recovery path. It watches the fill level of a receive data buffer and produces a signed frequency-offset word for a numerically controlled output clock. The word is zero when no correction is needed. The buffer and the oscillator sit outside the block.

After reset the block waits in an idle mode until the first data-period tick. That tick starts a timed free-run phase. During free run the offset word stays at zero while the buffer fills. The length of this phase is eight times a programmed initialization count. The block then enters locking mode. On every tick in locking mode it forms the fill error, damps it with a programmable arithmetic right shift, and accumulates it in an integrator. The integrator has anti-windup. The output word is the integrator plus the damped error, clamped to a programmed tuning range.

A restart input sends the loop back to free run without a full reset. This is used, for example, after the buffer is re-initialized. Flags report when the output is pinned at the upper or the lower limit.

Top module: `acr_freq_ctrl`

## Requirements
- R1: After rst_ni is released, mode_o is 00 (idle), ctrl_o is 0, and sat_hi_o and sat_lo_o are 0.
- R2: In idle, the first tick_i moves mode_o to 01 (free run) and loads a counter with 8×init_cnt_i. Mode 10 (locking) is reached on the max(8×init_cnt_i,1)-th tick counted after that entry. mode_o never takes the value 11.
- R3: While mode_o is 00 or 01, ctrl_o is 0 and both saturation flags are 0, whatever the fill, target, shift and range inputs are.
- R4: On a tick in locking mode, the step is s = floor((fill_i − target_i) / 2^shift_i). Both fill values are unsigned 16-bit, and the shift is an arithmetic shift that rounds toward minus infinity.
- R5: On that tick the integrator updates as I ← clamp(I + s, −range_i, +range_i), where range_i is an unsigned 15-bit magnitude. Then ctrl_o ← clamp(I + s, −range_i, +range_i), using the new I, as a signed 16-bit two's complement value.
- R6: On that same tick, sat_hi_o is set exactly when the unclamped I + s is greater than +range_i, and sat_lo_o exactly when it is less than −range_i. A value equal to a limit sets neither flag.
- R7: ctrl_o, sat_hi_o, sat_lo_o and mode_o change only on a tick_i or a restart_i. Fill and target changes with no tick have no effect.
- R8: restart_i has priority over tick_i. It sets mode_o to 01, clears ctrl_o, the flags and the integrator, and reloads the free-run counter from init_cnt_i.
- R9: init_cnt_i is 8 bits wide, which is two bits wider than a 6-bit initial-fill field. A count of 255 gives a free run of 2040 ticks.
- R10: A fill far below target drives ctrl_o to −range_i with sat_lo_o set. The output stays at −range_i while the error stays negative. It recovers as soon as positive error is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Return to free run, clear integrator |
| tick_i | input | 1 | One-cycle data-period strobe |
| fill_i | input | 16 | Current buffer fill, unsigned |
| target_i | input | 16 | Target buffer fill, unsigned |
| shift_i | input | 4 | Damping right-shift amount |
| range_i | input | 15 | Tuning range magnitude, unsigned |
| init_cnt_i | input | 8 | Free-run length in units of 8 ticks |
| ctrl_o | output | 16 | Signed frequency-offset word |
| mode_o | output | 2 | 00 idle, 01 free run, 10 locking |
| sat_hi_o | output | 1 | Output clamped at +range |
| sat_lo_o | output | 1 | Output clamped at −range |

## Verification
The locking loop is driven through a sequence of fill and target pairs:
- Zero error tests for offset bias.
- Small odd errors of both signs, with shift 1, test the floor rounding of negative steps.
- Full-scale errors with shift 15 test the step width and sign extension.
- Runs of large positive and negative errors push the output into each clamp. They check that the flags rise only above a limit, not at it.
- Range shrink and zero-range patterns test integrator anti-windup.

A sustained large deficit followed by a zero error and then a positive error tells a loop that recovers promptly apart from one that has wound up. Free-run length tests use counts 0, 2 and 255, and a restart during locking checks that the integrator is cleared.

// File: rtl/acr_pkg.sv
package acr_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_FREE = 2'b01,
    MODE_LOCK = 2'b10
  } acr_mode_e;

endpackage

// File: rtl/acr_free_timer.sv
module acr_free_timer
  import acr_pkg::*;
#(
  parameter int INIT_W = 8,
  parameter int MULT_LOG2 = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              tick_i,
  input  logic [INIT_W-1:0] init_cnt_i,
  output acr_mode_e         mode_o
);

  localparam int CW = INIT_W + MULT_LOG2;

  acr_mode_e     mode_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_val;

  assign load_val = {init_cnt_i, {MULT_LOG2{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE;
      cnt_q  <= '0;
    end else if (restart_i) begin
      mode_q <= MODE_FREE;
      cnt_q  <= load_val;
    end else if (tick_i) begin
      unique case (mode_q)
        MODE_IDLE: begin
          mode_q <= MODE_FREE;
          cnt_q  <= load_val;
        end
        MODE_FREE: begin
          // a zero count still spends one tick in free run
          if (cnt_q <= CW'(1)) mode_q <= MODE_LOCK;
          else                 cnt_q  <= cnt_q - CW'(1);
        end
        default: mode_q <= MODE_LOCK;
      endcase
    end
  end

  assign mode_o = mode_q;

  a_r2_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'b11);

  a_r2_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_LOCK && !restart_i) |=> mode_q == MODE_LOCK);

  a_r8_restart_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> mode_q == MODE_FREE);

endmodule

// File: rtl/acr_err_scale.sv
module acr_err_scale #(
  parameter int FILL_W  = 16,
  parameter int SHIFT_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [FILL_W-1:0]        fill_i,
  input  logic [FILL_W-1:0]        target_i,
  input  logic [SHIFT_W-1:0]       shift_i,
  output logic signed [FILL_W:0]   step_o
);

  logic signed [FILL_W:0] err;

  always_comb begin
    err    = $signed({1'b0, fill_i}) - $signed({1'b0, target_i});
    step_o = err >>> shift_i;
  end

  // R4: step keeps the sign of the error
  a_r4_step_sign_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i < target_i) |-> step_o[FILL_W]);

  a_r4_step_sign_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i >= target_i) |-> !step_o[FILL_W]);

endmodule

// File: rtl/acr_integ.sv
module acr_integ #(
  parameter int STEP_W  = 17,
  parameter int RANGE_W = 15,
  parameter int CTRL_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     en_i,
  input  logic signed [STEP_W-1:0] step_i,
  input  logic [RANGE_W-1:0]       range_i,
  output logic signed [CTRL_W-1:0] ctrl_o,
  output logic                     sat_hi_o,
  output logic                     sat_lo_o
);

  localparam int IW = CTRL_W + GUARD_W;

  logic signed [IW-1:0] integ_q, integ_d;
  logic signed [IW-1:0] step_x, rng_pos, rng_neg;
  logic signed [IW-1:0] acc_sum, out_sum, out_clamp;
  logic signed [CTRL_W-1:0] ctrl_q;
  logic hi_q, lo_q;

  always_comb begin
    step_x  = IW'(step_i);
    rng_pos = $signed({{(IW-RANGE_W){1'b0}}, range_i});
    rng_neg = -rng_pos;
    acc_sum = integ_q + step_x;
    if (acc_sum > rng_pos)      integ_d = rng_pos;
    else if (acc_sum < rng_neg) integ_d = rng_neg;
    else                        integ_d = acc_sum;
    out_sum = integ_d + step_x;
    if (out_sum > rng_pos)      out_clamp = rng_pos;
    else if (out_sum < rng_neg) out_clamp = rng_neg;
    else                        out_clamp = out_sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_q <= '0;
      ctrl_q  <= '0;
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
    end else if (clear_i) begin
      integ_q <= '0;
      ctrl_q  <= '0;
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
    end else if (en_i) begin
      integ_q <= integ_d;
      ctrl_q  <= out_clamp[CTRL_W-1:0];
      hi_q    <= out_sum > rng_pos;
      lo_q    <= out_sum < rng_neg;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign sat_hi_o = hi_q;
  assign sat_lo_o = lo_q;

  a_r5_out_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i) |=>
      ($signed({1'b0, $past(range_i)}) >= ctrl_q &&
       -$signed({1'b0, $past(range_i)}) <= ctrl_q));

  a_r6_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_q && lo_q));

  a_r6_hi_pinned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i) |=>
      (!hi_q || ctrl_q == $signed({1'b0, $past(range_i)})));

  a_r6_lo_pinned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i) |=>
      (!lo_q || ctrl_q == -$signed({1'b0, $past(range_i)})));

endmodule

// File: rtl/acr_freq_ctrl.sv
module acr_freq_ctrl
  import acr_pkg::*;
#(
  parameter int FILL_W    = 16,
  parameter int SHIFT_W   = 4,
  parameter int RANGE_W   = 15,
  parameter int CTRL_W    = 16,
  parameter int INIT_W    = 8,
  parameter int MULT_LOG2 = 3,
  parameter int GUARD_W   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     restart_i,
  input  logic                     tick_i,
  input  logic [FILL_W-1:0]        fill_i,
  input  logic [FILL_W-1:0]        target_i,
  input  logic [SHIFT_W-1:0]       shift_i,
  input  logic [RANGE_W-1:0]       range_i,
  input  logic [INIT_W-1:0]        init_cnt_i,
  output logic signed [CTRL_W-1:0] ctrl_o,
  output logic [1:0]               mode_o,
  output logic                     sat_hi_o,
  output logic                     sat_lo_o
);

  localparam int STEP_W = FILL_W + 1;

  acr_mode_e               mode;
  logic signed [STEP_W-1:0] step;
  logic                    loop_en;

  acr_free_timer #(
    .INIT_W    (INIT_W),
    .MULT_LOG2 (MULT_LOG2)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart_i),
    .tick_i     (tick_i),
    .init_cnt_i (init_cnt_i),
    .mode_o     (mode)
  );

  acr_err_scale #(
    .FILL_W  (FILL_W),
    .SHIFT_W (SHIFT_W)
  ) u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fill_i   (fill_i),
    .target_i (target_i),
    .shift_i  (shift_i),
    .step_o   (step)
  );

  assign loop_en = tick_i && (mode == MODE_LOCK);

  acr_integ #(
    .STEP_W  (STEP_W),
    .RANGE_W (RANGE_W),
    .CTRL_W  (CTRL_W),
    .GUARD_W (GUARD_W)
  ) u_integ (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (restart_i),
    .en_i     (loop_en),
    .step_i   (step),
    .range_i  (range_i),
    .ctrl_o   (ctrl_o),
    .sat_hi_o (sat_hi_o),
    .sat_lo_o (sat_lo_o)
  );

  assign mode_o = mode;

  a_r3_zero_outside_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != MODE_LOCK) |-> (ctrl_o == '0 && !sat_hi_o && !sat_lo_o));

  a_r7_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=>
      ($stable(ctrl_o) && $stable(mode_o) && $stable(sat_hi_o) && $stable(sat_lo_o)));

  a_r8_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (ctrl_o == '0 && !sat_hi_o && !sat_lo_o));

endmodule

// File: tb/acr_freq_ctrl_bench.sv
module acr_freq_ctrl_bench;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               restart = 1'b0;
  logic               tick = 1'b0;
  logic [15:0]        fill = '0;
  logic [15:0]        target = '0;
  logic [3:0]         shift = '0;
  logic [14:0]        range_v = '0;
  logic [7:0]         init_cnt = '0;
  logic signed [15:0] ctrl;
  logic [1:0]         mode;
  logic               sat_hi, sat_lo;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  acr_freq_ctrl u_acr_freq_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .restart_i  (restart),
    .tick_i     (tick),
    .fill_i     (fill),
    .target_i   (target),
    .shift_i    (shift),
    .range_i    (range_v),
    .init_cnt_i (init_cnt),
    .ctrl_o     (ctrl),
    .mode_o     (mode),
    .sat_hi_o   (sat_hi),
    .sat_lo_o   (sat_lo)
  );

  typedef struct packed {
    logic [15:0]        fill;
    logic [15:0]        tgt;
    logic [3:0]         sh;
    logic [14:0]        rng;
    logic signed [15:0] exp_ctrl;
    logic               exp_hi;
    logic               exp_lo;
  } vec_t;

  // locking-mode sequence from a cleared integrator (R4 R5 R6)
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{16'd1000,  16'd1000,  4'd0,  15'd1000, 16'sd0,    1'b0, 1'b0},
    '{16'd1010,  16'd1000,  4'd1,  15'd1000, 16'sd10,   1'b0, 1'b0},
    '{16'd990,   16'd1000,  4'd1,  15'd1000, -16'sd5,   1'b0, 1'b0},
    '{16'd993,   16'd1000,  4'd1,  15'd1000, -16'sd8,   1'b0, 1'b0},
    '{16'd1000,  16'd1000,  4'd2,  15'd1000, -16'sd4,   1'b0, 1'b0},
    '{16'd3000,  16'd1000,  4'd2,  15'd1000, 16'sd996,  1'b0, 1'b0},
    '{16'd3000,  16'd1000,  4'd2,  15'd1000, 16'sd1000, 1'b1, 1'b0},
    '{16'd3000,  16'd1000,  4'd2,  15'd1000, 16'sd1000, 1'b1, 1'b0},
    '{16'd1000,  16'd1000,  4'd0,  15'd1000, 16'sd1000, 1'b0, 1'b0},
    '{16'd0,     16'd4,     4'd3,  15'd1000, 16'sd998,  1'b0, 1'b0},
    '{16'd1000,  16'd1000,  4'd0,  15'd200,  16'sd200,  1'b0, 1'b0},
    '{16'd65535, 16'd0,     4'd15, 15'd200,  16'sd200,  1'b1, 1'b0},
    '{16'd1500,  16'd1000,  4'd0,  15'd0,    16'sd0,    1'b1, 1'b0},
    '{16'd0,     16'd65535, 4'd15, 15'd300,  -16'sd4,   1'b0, 1'b0},
    '{16'd2000,  16'd1000,  4'd0,  15'd300,  16'sd300,  1'b1, 1'b0},
    '{16'd0,     16'd2000,  4'd0,  15'd300,  -16'sd300, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input int ec, input bit eh, input bit el);
    chk(ctrl == 16'(ec), {tag, " ctrl"}, int'(ctrl), ec);
    chk(sat_hi == eh, {tag, " sat_hi"}, int'(sat_hi), int'(eh));
    chk(sat_lo == el, {tag, " sat_lo"}, int'(sat_lo), int'(el));
  endtask

  task automatic do_tick(input logic [15:0] f, input logic [15:0] t,
                         input logic [3:0] s, input logic [14:0] r);
    @(negedge clk);
    fill = f; target = t; shift = s; range_v = r; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_restart(input logic [7:0] n, input bit with_tick);
    @(negedge clk);
    init_cnt = n; restart = 1'b1; tick = with_tick;
    @(negedge clk);
    restart = 1'b0; tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mode == 2'b00, "R1 mode", int'(mode), 0);
    chk_out("R1", 0, 1'b0, 1'b0);

    // R2 R3: idle -> free run, 8*2 ticks of free run with varying fill
    init_cnt = 8'd2;
    do_tick(16'd5, 16'd1000, 4'd0, 15'd1000);
    chk(mode == 2'b01, "R2 enter free", int'(mode), 1);
    for (int i = 0; i < 15; i++) do_tick(16'(i * 3000), 16'd1000, 4'd0, 15'd1000);
    chk(mode == 2'b01, "R2 still free after 15", int'(mode), 1);
    chk_out("R3 free run", 0, 1'b0, 1'b0);
    do_tick(16'd60000, 16'd0, 4'd0, 15'd1000);
    chk(mode == 2'b10, "R2 lock after 16", int'(mode), 2);
    chk_out("R3 lock entry", 0, 1'b0, 1'b0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      do_tick(VEC[v].fill, VEC[v].tgt, VEC[v].sh, VEC[v].rng);
      chk_out($sformatf("R5 R6 vec %0d", v), int'(VEC[v].exp_ctrl), VEC[v].exp_hi, VEC[v].exp_lo);
    end

    // R7: no tick, inputs wander
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      fill = 16'(i * 9000); target = 16'd7; range_v = 15'd5;
    end
    @(negedge clk);
    chk(mode == 2'b10, "R7 mode hold", int'(mode), 2);
    chk_out("R7 hold", -300, 1'b0, 1'b1);

    // R10: deep deficit, hold at floor, recovery
    for (int i = 0; i < 3; i++) begin
      do_tick(16'd0, 16'd60000, 4'd0, 15'd1000);
      chk_out("R10 floor", -1000, 1'b0, 1'b1);
    end
    do_tick(16'd500, 16'd500, 4'd0, 15'd1000);
    chk_out("R10 zero err", -1000, 1'b0, 1'b0);
    do_tick(16'd900, 16'd500, 4'd0, 15'd1000);
    chk_out("R10 recover", -200, 1'b0, 1'b0);

    // R8: restart with tick in the same cycle, count 0
    do_restart(8'd0, 1'b1);
    chk(mode == 2'b01, "R8 restart priority", int'(mode), 1);
    chk_out("R8 restart", 0, 1'b0, 1'b0);
    do_tick(16'd1010, 16'd1000, 4'd0, 15'd1000);
    chk(mode == 2'b10, "R2 zero count one tick", int'(mode), 2);
    do_tick(16'd1010, 16'd1000, 4'd0, 15'd1000);
    chk_out("R8 integ cleared", 20, 1'b0, 1'b0);

    // R9: widest count, 2040 ticks
    do_restart(8'd255, 1'b0);
    for (int i = 0; i < 2039; i++) do_tick(16'd0, 16'd100, 4'd0, 15'd1000);
    chk(mode == 2'b01, "R9 free at 2039", int'(mode), 1);
    chk_out("R9 free", 0, 1'b0, 1'b0);
    do_tick(16'd0, 16'd100, 4'd0, 15'd1000);
    chk(mode == 2'b10, "R9 lock at 2040", int'(mode), 2);

    // R1: reset mid-lock
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mode == 2'b00, "R1 re-reset mode", int'(mode), 0);
    chk_out("R1 re-reset", 0, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule